// File: doc/BRIEF.md
# Burst Low-Address Sequencer

This block produces the two least-significant address bits of a four-beat memory burst. A load strobe captures the low bits of the external address as the burst's starting beat. Each cycle in which the active-low advance input is asserted and no load occurs moves the burst on by one beat. The upper address bits are registered elsewhere and are not touched here, so a burst always stays inside its aligned four-word block.

Two beat orders are available, selected at run time. In linear order the start value is counted upward and wraps modulo four. In interleaved order the start value is XORed with an internal beat index that runs 0, 1, 2, 3. The block keeps the start value and the beat index as state, and forms the output from them through the order currently selected. Changing the mode mid-burst therefore re-maps the same beat index without disturbing the state.

Top module: `burst_addr_gen`

## Requirements
- R1: With mode_i = 0 (linear), each advance sets addr_o to the previous addr_o plus one, modulo four (e.g. 2, 3, 0, 1).
- R2: With mode_i = 1 (interleaved), addr_o equals the loaded start value XOR the beat index, the index counting 0, 1, 2, 3 (e.g. 1, 0, 3, 2 from a start of 1).
- R3: In the cycle after a clock edge with load_i = 1, addr_o equals the start_i value sampled at that edge, in either mode.
- R4: When load_i = 1 and adv_ni = 0 at the same edge, the load wins: addr_o shows start_i and the beat index restarts at 0.
- R5: When load_i = 0 and adv_ni = 1 at an edge, and mode_i does not change, addr_o keeps its value.
- R6: After the fourth beat, a further advance returns to the first beat of the same burst (the start value), in both orders, with no carry out of the two bits.
- R7: While rst_ni = 0, addr_o is 0 at once, without waiting for a clock edge; after release the start value and beat index are both 0, so the first linear advance gives 1.
- R8: mode_i acts on the output combinationally: with the state held, switching mode_i changes addr_o from start XOR index to start plus index for the same beat index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Starts a burst from start_i |
| adv_ni | input | 1 | Advance to next beat, active low |
| mode_i | input | 1 | Beat order: 0 linear, 1 interleaved |
| start_i | input | 2 | Low bits of the external start address |
| addr_o | output | 2 | Current low burst address |

## Verification
The properties assume mode_i is held steady across the edge that a step or hold check spans; a mode change there is a deliberate re-mapping covered by R8, so the hold and step properties only judge cycles in which mode_i is unchanged. They also assume inputs are settled at the rising edge. The stimulus changes every input on the falling edge and changes mode_i only in a cycle whose expected value accounts for the new order, so the sampled values always meet those assumptions.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_beat_state.sv
module burst_beat_state #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] start_i,
  output logic [W-1:0] base_o,
  output logic [W-1:0] idx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= '0;
      idx_o  <= '0;
    end else if (load_i) begin
      base_o <= start_i;
      idx_o  <= '0;
    end else if (step_i) begin
      idx_o  <= idx_o + 1'b1; // wraps inside the block
    end
  end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_addr_pkg::*;
#(
  parameter int unsigned W = 2
) (
  input  burst_order_e order_i,
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] idx_i,
  output logic [W-1:0] addr_o
);
  always_comb begin
    unique case (order_i)
      ORD_INTERLEAVE: addr_o = base_i ^ idx_i;
      default:        addr_o = base_i + idx_i;
    endcase
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         adv_ni,
  input  logic         mode_i,
  input  logic [W-1:0] start_i,
  output logic [W-1:0] addr_o
);
  logic [W-1:0] base_q;
  logic [W-1:0] idx_q;
  logic         step;
  burst_order_e order;

  assign step  = ~adv_ni;
  assign order = burst_order_e'(mode_i);

  burst_beat_state #(.W(W)) u_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .step_i  (step),
    .start_i (start_i),
    .base_o  (base_q),
    .idx_o   (idx_q)
  );

  burst_order_map #(.W(W)) u_map (
    .order_i (order),
    .base_i  (base_q),
    .idx_i   (idx_q),
    .addr_o  (addr_o)
  );
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int unsigned W = 2
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         load_i,
  input logic         adv_ni,
  input logic         mode_i,
  input logic [W-1:0] start_i,
  input logic [W-1:0] addr_o
);
  p_reset_zero_r7: assert property (@(posedge clk_i)
    !rst_ni |-> addr_o == '0);

  p_load_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_o == $past(start_i));

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && adv_ni) |=> (!$stable(mode_i) || $stable(addr_o)));

  p_lin_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_ni && !mode_i) |=>
      (mode_i || addr_o == W'($past(addr_o) + 1'b1)));

  p_ilv_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_ni && mode_i) |=>
      (!mode_i || addr_o[0] != $past(addr_o[0])));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .load_i  (load_i),
  .adv_ni  (adv_ni),
  .mode_i  (mode_i),
  .start_i (start_i),
  .addr_o  (addr_o)
);

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       load_i = 1'b0;
  logic       adv_ni = 1'b1;
  logic       mode_i = 1'b0;
  logic [1:0] start_i = 2'd0;
  logic [1:0] addr_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk_i = ~clk_i;

  burst_addr_gen #(.W(2)) uut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .adv_ni  (adv_ni),
    .mode_i  (mode_i),
    .start_i (start_i),
    .addr_o  (addr_o)
  );

  // {load, adv_n, mode, start[1:0], expected[1:0]}
  localparam int N = 15;
  localparam logic [6:0] VEC [N] = '{
    {1'b1, 1'b1, 1'b0, 2'd2, 2'd2}, // R3 load linear
    {1'b0, 1'b0, 1'b0, 2'd0, 2'd3}, // R1
    {1'b0, 1'b0, 1'b0, 2'd0, 2'd0}, // R1 wrap mod 4
    {1'b0, 1'b0, 1'b0, 2'd0, 2'd1}, // R1
    {1'b0, 1'b0, 1'b0, 2'd0, 2'd2}, // R6 fifth beat = start
    {1'b0, 1'b1, 1'b0, 2'd3, 2'd2}, // R5 hold
    {1'b1, 1'b1, 1'b1, 2'd1, 2'd1}, // R3 load interleaved
    {1'b0, 1'b0, 1'b1, 2'd0, 2'd0}, // R2
    {1'b0, 1'b0, 1'b1, 2'd0, 2'd3}, // R2
    {1'b0, 1'b0, 1'b1, 2'd0, 2'd2}, // R2
    {1'b0, 1'b0, 1'b1, 2'd0, 2'd1}, // R6 interleaved wrap
    {1'b1, 1'b0, 1'b1, 2'd3, 2'd3}, // R4 load beats advance
    {1'b0, 1'b1, 1'b1, 2'd0, 2'd3}, // R5 hold
    {1'b0, 1'b0, 1'b1, 2'd0, 2'd2}, // R2 3^1
    {1'b0, 1'b1, 1'b0, 2'd0, 2'd0}  // R8 same index, linear 3+1
  };

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: addr_o=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic ld, input logic an, input logic md, input logic [1:0] st);
    @(negedge clk_i);
    load_i  = ld;
    adv_ni  = an;
    mode_i  = md;
    start_i = st;
    @(posedge clk_i);
    #2;
  endtask

  initial begin
    #1;
    chk("R7 reset", addr_o, 2'd0);
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < N; i++) begin
      drive(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3:2]);
      chk($sformatf("vec%0d", i), addr_o, VEC[i][1:0]);
    end

    // R8: hold state, flip mode back to interleaved: base 3, index 1 -> 2
    @(negedge clk_i);
    mode_i = 1'b1;
    #1;
    chk("R8 mode flip", addr_o, 2'd2);

    // R4: load with advance from mid-burst, then advance once
    drive(1'b1, 1'b0, 1'b0, 2'd1);
    chk("R4 load priority", addr_o, 2'd1);
    drive(1'b0, 1'b0, 1'b0, 2'd0);
    chk("R4 index restarted", addr_o, 2'd2);

    // R5: long hold while start_i wiggles
    drive(1'b0, 1'b1, 1'b0, 2'd3);
    drive(1'b0, 1'b1, 1'b0, 2'd0);
    chk("R5 hold two edges", addr_o, 2'd2);

    // R7: asynchronous reset mid-burst
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R7 async reset", addr_o, 2'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    drive(1'b0, 1'b0, 1'b0, 2'd3);
    chk("R7 first advance after reset", addr_o, 2'd1);

    @(negedge clk_i);
    adv_ni = 1'b1;
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 2000 && !done; c++) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule